// File: doc/BRIEF.md
# Output Audio Stream Control Register

This block is the control word of one outbound audio stream channel. A bus master writes and reads it through a single-cycle memory-mapped port. The block turns the master's run and reset choices into request lines for the stream's DMA engine. Its readback shows what the engine has actually done, not what was last written. The word also carries a 4-bit stream tag, which the link framer puts on every frame of this stream, and a fixed set of read-only capability bits.

A second word, on the same port, collects three stream events: FIFO underrun, completion of a buffer flagged for notification, and descriptor fault. Each event is latched whether or not its enable is set, and is cleared by writing a one to its bit. The single interrupt line is the OR of every latched event ANDed with its enable.

A stream reset clears the tag, the enables, the run request and the event word, and is also the reset line for the stream FIFO and the cadence generator. The block refuses a reset request made while the stream is still running. It reports the refusal with a one-cycle error pulse.

Top module: `astrm_ctl`

## Requirements
- R1: After power-on reset, the control word (bus_addr=0) reads 0x00040000 and the event word (bus_addr=1) reads 0x00000000.
- R2: Control bits 23:20 (stream tag; 0 means unused, 1 to 15 select streams 1 to 15) and bits 4:2 (enables for descriptor fault, underrun and completion, in that order from bit 4 down) are stored by a write to bus_addr=0 and read back in the cycle after the write.
- R3: Control bits 31:24 and 19:5 ignore writes. Bit 18 always reads 1 and the rest read 0.
- R4: dma_run is high exactly when the stored run request (written through bit 1) is set and sync_hold is low.
- R5: cad_rst is high for one cycle, in the cycle after a control write that sets bit 1 while the stored run request was clear.
- R6: Control bit 1 reads 1 while the run request is stored or eng_running is high. After bit 1 is written 0, it keeps reading 1 until eng_running falls.
- R7: A control write with bit 0 set is refused when bit 1 reads 1 and no reset is pending. dma_srst stays low, and proto_err is high for the one following cycle.
- R8: dma_srst follows the accepted value of control bit 0 from the cycle after the write. Control bit 0 reads the eng_in_reset input, so it turns 1 only when the engine reports entry into reset and 0 only when it reports readiness.
- R9: While dma_srst is high, the tag, the enables, the run request and all event bits are cleared from the next cycle on, and writes to them are ignored.
- R10: Event bit 2 (completion), bit 3 (underrun) and bit 4 (descriptor fault) of bus_addr=1 are set in the cycle after their event input is high, whatever the enables. A write of 1 clears a bit, and an event arriving in the cycle of the clear wins.
- R11: irq is high exactly when some event bit and its enable in the control word are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_addr | input | 1 | Word select: 0 control, 1 events |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word (combinational) |
| sync_hold | input | 1 | Holds the engine off while high |
| eng_running | input | 1 | Engine reports that it is moving data |
| eng_in_reset | input | 1 | Engine reports that it is in reset |
| ev_underrun | input | 1 | FIFO underrun event (samples dropped) |
| ev_ioc_done | input | 1 | Flagged buffer completed |
| ev_desc_err | input | 1 | Descriptor fault |
| dma_run | output | 1 | Run enable to the DMA engine |
| dma_srst | output | 1 | Stream reset to engine, FIFO and stream registers |
| cad_rst | output | 1 | One-cycle cadence generator reset |
| irq | output | 1 | Stream interrupt |
| proto_err | output | 1 | One-cycle pulse on a refused reset request |

## Verification
On every cycle, the assertions check that the fixed bits never move and that bit 0 tracks eng_in_reset. They also check that bit 1 stays up while the engine runs, that the cadence and error pulses last one cycle, and that a pending reset silences run and interrupt. Only the bench scenarios can show the rest. These are the lagging readback across a slow stop and a slow reset exit, the refusal of a reset while running, the sticky events latched with their enable off, and the race between a clear and a new event. A behavioural model in the bench also checks every output against its own state on each clock.

// File: rtl/astrm_pkg.sv
package astrm_pkg;
  localparam int DATA_W   = 32;
  localparam int TAG_W    = 4;
  localparam int TAG_LSB  = 20;
  localparam int EVT_N    = 3;
  localparam int EVT_LSB  = 2;
  localparam int RUN_BIT  = 1;
  localparam int SRST_BIT = 0;
  localparam logic [DATA_W-1:0] FIXED_ONES = 32'h0004_0000;

  typedef enum logic {
    SEL_CTL = 1'b0,
    SEL_EVT = 1'b1
  } word_sel_e;
endpackage

// File: rtl/astrm_fields.sv
module astrm_fields #(
  parameter int TAG_W = 4,
  parameter int EVT_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [EVT_N-1:0] wr_en,
  input  logic             wr_run,
  input  logic             wr_srst,
  input  logic             eng_running,
  output logic [TAG_W-1:0] tag,
  output logic [EVT_N-1:0] en,
  output logic             run_req,
  output logic             srst_req,
  output logic             busy,
  output logic             cad_rst,
  output logic             proto_err
);
  logic refuse;

  assign busy   = run_req | eng_running;
  assign refuse = wr & wr_srst & ~srst_req & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag       <= '0;
      en        <= '0;
      run_req   <= 1'b0;
      srst_req  <= 1'b0;
      cad_rst   <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      cad_rst   <= 1'b0;
      proto_err <= refuse;
      if (wr) srst_req <= wr_srst & ~refuse;
      if (srst_req) begin
        tag     <= '0;
        en      <= '0;
        run_req <= 1'b0;
      end else if (wr) begin
        tag     <= wr_tag;
        en      <= wr_en;
        run_req <= wr_run;
        cad_rst <= wr_run & ~run_req;
      end
    end
  end
endmodule

// File: rtl/astrm_events.sv
module astrm_events #(
  parameter int EVT_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr,
  input  logic [EVT_N-1:0] w1c,
  input  logic [EVT_N-1:0] ev,
  output logic [EVT_N-1:0] sts
);
  for (genvar i = 0; i < EVT_N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 sts[i] <= 1'b0;
      else if (flush)             sts[i] <= 1'b0;
      else if (ev[i])             sts[i] <= 1'b1;
      else if (wr && w1c[i])      sts[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/astrm_ctl.sv
module astrm_ctl
  import astrm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sync_hold,
  input  logic              eng_running,
  input  logic              eng_in_reset,
  input  logic              ev_underrun,
  input  logic              ev_ioc_done,
  input  logic              ev_desc_err,
  output logic              dma_run,
  output logic              dma_srst,
  output logic              cad_rst,
  output logic              irq,
  output logic              proto_err
);
  localparam int TAG_MSB = TAG_LSB + TAG_W - 1;
  localparam int EVT_MSB = EVT_LSB + EVT_N - 1;

  logic             wr_ctl, wr_evt;
  logic [TAG_W-1:0] tag;
  logic [EVT_N-1:0] en, sts, ev_vec;
  logic             run_req, srst_req, busy;

  assign wr_ctl = bus_wr & (bus_addr == SEL_CTL);
  assign wr_evt = bus_wr & (bus_addr == SEL_EVT);
  assign ev_vec = {ev_desc_err, ev_underrun, ev_ioc_done};

  astrm_fields #(.TAG_W(TAG_W), .EVT_N(EVT_N)) u_fields (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (wr_ctl),
    .wr_tag      (bus_wdata[TAG_MSB:TAG_LSB]),
    .wr_en       (bus_wdata[EVT_MSB:EVT_LSB]),
    .wr_run      (bus_wdata[RUN_BIT]),
    .wr_srst     (bus_wdata[SRST_BIT]),
    .eng_running (eng_running),
    .tag         (tag),
    .en          (en),
    .run_req     (run_req),
    .srst_req    (srst_req),
    .busy        (busy),
    .cad_rst     (cad_rst),
    .proto_err   (proto_err)
  );

  astrm_events #(.EVT_N(EVT_N)) u_events (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (srst_req),
    .wr    (wr_evt),
    .w1c   (bus_wdata[EVT_MSB:EVT_LSB]),
    .ev    (ev_vec),
    .sts   (sts)
  );

  assign dma_run  = run_req & ~sync_hold;
  assign dma_srst = srst_req;
  assign irq      = |(sts & en);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == SEL_CTL) begin
      bus_rdata                  = FIXED_ONES;
      bus_rdata[TAG_MSB:TAG_LSB] = tag;
      bus_rdata[EVT_MSB:EVT_LSB] = en;
      bus_rdata[RUN_BIT]         = busy;
      bus_rdata[SRST_BIT]        = eng_in_reset;
    end else begin
      bus_rdata[EVT_MSB:EVT_LSB] = sts;
    end
  end
endmodule

// File: rtl/astrm_ctl_chk.sv
module astrm_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_addr,
  input logic [31:0] bus_rdata,
  input logic        eng_running,
  input logic        eng_in_reset,
  input logic        dma_run,
  input logic        dma_srst,
  input logic        cad_rst,
  input logic        irq,
  input logic        proto_err
);
  // R3
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 1'b0) |-> (bus_rdata[31:24] == 8'h00 && bus_rdata[19:5] == 15'h2000));
  // R6
  run_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 1'b0 && eng_running) |-> bus_rdata[1]);
  // R8
  srst_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 1'b0) |-> (bus_rdata[0] == eng_in_reset));
  // R5
  cad_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cad_rst |=> !cad_rst);
  // R7
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !dma_srst);
  // R7
  perr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> !proto_err);
  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_srst |=> (!irq && !dma_run));
endmodule

bind astrm_ctl astrm_ctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_rdata    (bus_rdata),
  .eng_running  (eng_running),
  .eng_in_reset (eng_in_reset),
  .dma_run      (dma_run),
  .dma_srst     (dma_srst),
  .cad_rst      (cad_rst),
  .irq          (irq),
  .proto_err    (proto_err)
);

// File: tb/astrm_ctl_tb.sv
module astrm_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sync_hold = 1'b0;
  logic        eng_running = 1'b0;
  logic        eng_in_reset = 1'b0;
  logic        ev_underrun = 1'b0;
  logic        ev_ioc_done = 1'b0;
  logic        ev_desc_err = 1'b0;
  logic        dma_run, dma_srst, cad_rst, irq, proto_err;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  astrm_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_hold(sync_hold),
    .eng_running(eng_running), .eng_in_reset(eng_in_reset),
    .ev_underrun(ev_underrun), .ev_ioc_done(ev_ioc_done), .ev_desc_err(ev_desc_err),
    .dma_run(dma_run), .dma_srst(dma_srst), .cad_rst(cad_rst), .irq(irq),
    .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
    end
  endtask

  // engine responders: follow requests after a few cycles
  int run_cnt = 0;
  int rst_cnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      eng_running = 1'b0; eng_in_reset = 1'b0; run_cnt = 0; rst_cnt = 0;
    end else begin
      if (dma_run != eng_running) begin
        run_cnt++;
        if (run_cnt >= 3) begin eng_running = dma_run; run_cnt = 0; end
      end else run_cnt = 0;
      if (dma_srst != eng_in_reset) begin
        rst_cnt++;
        if (rst_cnt >= 2) begin eng_in_reset = dma_srst; rst_cnt = 0; end
      end else rst_cnt = 0;
    end
  end

  // behavioural reference model
  logic [3:0] m_tag;
  logic [2:0] m_en, m_sts;
  logic       m_run, m_srst, m_cad, m_perr;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_tag = 0; m_en = 0; m_sts = 0; m_run = 0; m_srst = 0; m_cad = 0; m_perr = 0;
    end else begin
      bit wc, ws, rej, busy_now, new_srst;
      logic [2:0] evs, clr;
      busy_now = m_run | eng_running;
      wc = bus_wr && (bus_addr == 1'b0);
      ws = bus_wr && (bus_addr == 1'b1);
      rej = wc && bus_wdata[0] && !m_srst && busy_now;
      new_srst = wc ? (bus_wdata[0] && !rej) : m_srst;
      m_perr = rej;
      m_cad = 1'b0;
      evs = {ev_desc_err, ev_underrun, ev_ioc_done};
      clr = ws ? bus_wdata[4:2] : 3'b000;
      if (m_srst) begin
        m_tag = 0; m_en = 0; m_run = 0; m_sts = 0;
      end else begin
        m_sts = (m_sts & ~clr) | evs;
        if (wc) begin
          m_cad = bus_wdata[1] && !m_run;
          m_tag = bus_wdata[23:20]; m_en = bus_wdata[4:2]; m_run = bus_wdata[1];
        end
      end
      m_srst = new_srst;
    end
  end

  function automatic logic [31:0] model_rd(input logic a);
    logic [31:0] v;
    if (a == 1'b0) begin
      v = 32'h0004_0000;
      v[23:20] = m_tag; v[4:2] = m_en; v[1] = m_run | eng_running; v[0] = eng_in_reset;
    end else begin
      v = 32'h0; v[4:2] = m_sts;
    end
    return v;
  endfunction

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk(bus_rdata === model_rd(bus_addr), "R2 readback", bus_rdata, model_rd(bus_addr));
      chk(dma_run === (m_run & ~sync_hold), "R4 dma_run", {31'b0, dma_run}, {31'b0, m_run & ~sync_hold});
      chk(cad_rst === m_cad, "R5 cad_rst", {31'b0, cad_rst}, {31'b0, m_cad});
      chk(proto_err === m_perr, "R7 proto_err", {31'b0, proto_err}, {31'b0, m_perr});
      chk(dma_srst === m_srst, "R8 dma_srst", {31'b0, dma_srst}, {31'b0, m_srst});
      chk(irq === |(m_sts & m_en), "R11 irq", {31'b0, irq}, {31'b0, |(m_sts & m_en)});
    end
  end

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_for(input logic want_run, input logic want_rst);
    for (int i = 0; i < 40; i++) begin
      if (eng_running === want_run && eng_in_reset === want_rst) break;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic pulse_ev(input int which);
    @(negedge clk);
    if (which == 0) ev_ioc_done = 1'b1;
    if (which == 1) ev_underrun = 1'b1;
    if (which == 2) ev_desc_err = 1'b1;
    @(negedge clk);
    ev_ioc_done = 1'b0; ev_underrun = 1'b0; ev_desc_err = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    rd(1'b0, d); chk(d == 32'h0004_0000, "R1 ctl reset", d, 32'h0004_0000);
    rd(1'b1, d); chk(d == 32'h0, "R1 evt reset", d, 32'h0);

    wr(1'b0, 32'h0050_001C);
    rd(1'b0, d); chk(d == 32'h0054_001C, "R2 tag/enables", d, 32'h0054_001C);
    wr(1'b0, 32'hFFFF_FFE0);
    rd(1'b0, d); chk(d == 32'h00F4_0000, "R3 fixed bits", d, 32'h00F4_0000);

    sync_hold = 1'b1;
    wr(1'b0, 32'h0000_0002);
    chk(cad_rst == 1'b1, "R5 cad pulse", {31'b0, cad_rst}, 1);
    chk(dma_run == 1'b0, "R4 held off", {31'b0, dma_run}, 0);
    @(negedge clk); #1;
    chk(cad_rst == 1'b0, "R5 cad single", {31'b0, cad_rst}, 0);
    sync_hold = 1'b0; #1;
    chk(dma_run == 1'b1, "R4 released", {31'b0, dma_run}, 1);
    wait_for(1'b1, 1'b0);

    wr(1'b0, 32'h0000_0003);
    chk(proto_err == 1'b1, "R7 refused", {31'b0, proto_err}, 1);
    chk(dma_srst == 1'b0, "R7 no reset", {31'b0, dma_srst}, 0);

    wr(1'b0, 32'h0000_0000);
    rd(1'b0, d); chk(d[1] == 1'b1, "R6 lag stop", {31'b0, d[1]}, 1);
    wait_for(1'b0, 1'b0);
    rd(1'b0, d); chk(d[1] == 1'b0, "R6 stopped", {31'b0, d[1]}, 0);

    wr(1'b0, 32'h0000_0001);
    chk(dma_srst == 1'b1, "R8 reset req", {31'b0, dma_srst}, 1);
    rd(1'b0, d); chk(d[0] == 1'b0, "R8 not yet in reset", {31'b0, d[0]}, 0);
    wait_for(1'b0, 1'b1);
    rd(1'b0, d); chk(d[0] == 1'b1, "R8 in reset", {31'b0, d[0]}, 1);
    wr(1'b0, 32'h00A0_001D);
    rd(1'b0, d); chk(d == 32'h0004_0001, "R9 writes ignored", d, 32'h0004_0001);
    wr(1'b0, 32'h0000_0000);
    rd(1'b0, d); chk(d[0] == 1'b1, "R8 lag exit", {31'b0, d[0]}, 1);
    wait_for(1'b0, 1'b0);
    rd(1'b0, d); chk(d[0] == 1'b0, "R8 ready", {31'b0, d[0]}, 0);

    pulse_ev(1);
    rd(1'b1, d); chk(d == 32'h8, "R10 sticky underrun", d, 32'h8);
    chk(irq == 1'b0, "R11 masked", {31'b0, irq}, 0);
    wr(1'b0, 32'h0000_0008);
    chk(irq == 1'b1, "R11 enabled", {31'b0, irq}, 1);
    wr(1'b1, 32'h0000_0008);
    rd(1'b1, d); chk(d == 32'h0, "R10 w1c", d, 32'h0);
    chk(irq == 1'b0, "R11 cleared", {31'b0, irq}, 0);

    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 32'h4; ev_ioc_done = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ev_ioc_done = 1'b0;
    rd(1'b1, d); chk(d == 32'h4, "R10 event beats clear", d, 32'h4);
    chk(irq == 1'b0, "R11 ioc masked", {31'b0, irq}, 0);
    wr(1'b0, 32'h0000_0014);
    chk(irq == 1'b1, "R11 ioc enabled", {31'b0, irq}, 1);
    pulse_ev(2);
    rd(1'b1, d); chk(d == 32'h14, "R10 desc fault", d, 32'h14);

    wr(1'b0, 32'h0000_0001);
    @(negedge clk); #1;
    rd(1'b1, d); chk(d == 32'h0, "R9 events flushed", d, 32'h0);
    chk(irq == 1'b0, "R9 irq quiet", {31'b0, irq}, 0);
    wr(1'b0, 32'h0000_0000);
    wait_for(1'b0, 1'b0);
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule